// File: doc/BRIEF.md
# Sectored Cache Fill Controller

This block keeps the tag and line-state array of a direct-mapped cache whose sectors each hold two 32-byte lines under a single shared address tag, and it runs the miss sequencer that fills them. A requester offers one read lookup at a time. A lookup that hits returns its 64-bit word straight from the local data store. A lookup that misses is put into one of two classes. When the tag differs, the sector is taken over by the new tag. When the tag matches but the addressed line is Invalid, only that line is refilled. In both cases the block issues one burst read per line on a 64-bit memory port.

When the prefetch input is high as the lookup is accepted, the sequencer can follow the demanded line with a second burst for the sibling line of the same sector. That second burst starts in the cycle right after the first one ends. The requester gets its word as soon as the demanded line has arrived, while the prefetch is still running. A busy output holds off new lookups until every burst has finished.

Address layout with default parameters: bits [4:3] pick the 64-bit word inside a line, bit [5] picks the line inside the sector, bits [8:6] pick the sector, and bits [31:9] form the tag.

Top module: `sector_fill_ctrl`

## Requirements
- R1: Reset sets every line of every sector to Invalid and leaves busy, resp_done and mem_req low, so the first lookup of any address is a miss.
- R2: A lookup whose tag matches, on a line whose state is not Invalid, is a hit. resp_done and resp_hit rise one cycle after acceptance, resp_data holds the 64-bit word selected by address bits [4:3], and no burst is issued.
- R3: A lookup whose tag differs from the sector's tag is a tag-miss fill. It issues one burst at the line-aligned address of the demanded line, installs the new tag, and sets the sibling line to Invalid, so a later lookup to the sibling misses.
- R4: A lookup whose tag matches on an Invalid line is a tag-hit fill. It issues a burst only for the demanded line, and the sibling line keeps its state, so a valid sibling still hits afterwards with no burst.
- R5: A burst starts with a one-cycle mem_req pulse and consists of 4 beats, each marked by mem_rvalid. Beat k carries bytes 8k to 8k+7 of the line, in ascending order. Idle cycles between beats are tolerated.
- R6: On a miss, resp_done rises with resp_hit low one cycle after the final beat of the demanded line's burst. resp_data then holds the demanded word, and the response does not wait for a prefetch burst.
- R7: If prefetch is requested at acceptance and the sibling line is Invalid once the miss has been classified, a second burst follows for the sibling line. Its address equals the demanded address with bit 5 inverted, and its mem_req pulse comes in the cycle right after the demanded burst's final beat.
- R8: No prefetch burst is issued when prefetch is not requested, or when a tag-hit fill finds the sibling already valid.
- R9: Every filled line, whether demanded or prefetched, becomes Exclusive, so later lookups to it hit.
- R10: busy is high from the cycle after a miss is accepted until the cycle after the last beat of the last burst. A lookup offered while busy is ignored, and the burst address stays stable during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup offered this cycle |
| req_addr | input | ADDR_W | Byte address of the lookup |
| pf_en | input | 1 | Allow a sibling-line prefetch for this lookup |
| busy | output | 1 | Sequencer active; lookups are not accepted |
| resp_done | output | 1 | Response valid for one cycle |
| resp_hit | output | 1 | Response came from a hit |
| resp_data | output | DATA_W | Demanded 64-bit word |
| mem_req | output | 1 | One-cycle burst start |
| mem_addr | output | ADDR_W | Line-aligned burst address |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | DATA_W | Burst beat data |

## Verification
The bench works through the two miss classes on the same sectors. A design that cleared the sibling line on a tag-hit fill would miss where a hit is expected, and one that kept the sibling valid across a tag change would hit on stale data. Prefetch is tested in three forms: taken on a tag miss, skipped because the sibling is valid, and taken with idle cycles inside the bursts. A sequencer that inserted a gap before the second burst, fetched the sibling first, or held the response back until the prefetch finished is caught by the burst log and the response timing. Finally, a lookup offered in the middle of a fill, to an address that would hit, must yield neither a response nor a burst.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_DREQ = 3'd1,
        SQ_DDAT = 3'd2,
        SQ_PREQ = 3'd3,
        SQ_PDAT = 3'd4
    } seq_e;

endpackage

// File: rtl/sfc_tag_store.sv
module sfc_tag_store
    import sfc_pkg::*;
#(
    parameter int SECTORS = 8,
    parameter int TAG_W   = 23,
    localparam int IDX_W  = $clog2(SECTORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output line_st_e         rd_st [2],
    input  logic             tag_we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [1:0]       st_we,
    input  line_st_e         st_wd [2]
);

    logic [TAG_W-1:0] tag_mem [SECTORS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SECTORS; s++) tag_mem[s] <= '0;
        end else if (tag_we) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag = tag_mem[rd_idx];

    // one state bank per line of the sector
    for (genvar ln = 0; ln < 2; ln++) begin : g_line
        line_st_e st_mem [SECTORS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SECTORS; s++) st_mem[s] <= LS_I;
            end else if (st_we[ln]) begin
                st_mem[wr_idx] <= st_wd[ln];
            end
        end

        assign rd_st[ln] = st_mem[rd_idx];
    end

endmodule

// File: rtl/sfc_data_store.sv
module sfc_data_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sfc_fill_seq.sv
module sfc_fill_seq
    import sfc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 32,
    parameter int SECTORS    = 8,
    localparam int BEAT_BYTES = DATA_W / 8,
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
    localparam int BEAT_W     = $clog2(BEATS),
    localparam int OFF_LSB    = $clog2(BEAT_BYTES),
    localparam int LINE_LSB   = $clog2(LINE_BYTES),
    localparam int IDX_W      = $clog2(SECTORS),
    localparam int IDX_LSB    = LINE_LSB + 1,
    localparam int TAG_LSB    = IDX_LSB + IDX_W,
    localparam int TAG_W      = ADDR_W - TAG_LSB,
    localparam int DS_AW      = IDX_W + 1 + BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              pf_en,
    output logic              busy,
    output logic              resp_done,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  ts_rd_idx,
    input  logic [TAG_W-1:0]  ts_rd_tag,
    input  line_st_e          ts_rd_st [2],
    output logic              ts_tag_we,
    output logic [IDX_W-1:0]  ts_wr_idx,
    output logic [TAG_W-1:0]  ts_wr_tag,
    output logic [1:0]        ts_st_we,
    output line_st_e          ts_st_wd [2],
    output logic [DS_AW-1:0]  ds_raddr,
    input  logic [DATA_W-1:0] ds_rdata,
    output logic              ds_we,
    output logic [DS_AW-1:0]  ds_waddr,
    output logic [DATA_W-1:0] ds_wdata
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        seq_e              fsm;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic              line;
        logic [BEAT_W-1:0] beat;
        logic              pf;
        logic [BEAT_W-1:0] cnt;
        logic              done;
        logic              hit;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;

    // lookup address fields
    logic [TAG_W-1:0]  r_tag;
    logic [IDX_W-1:0]  r_idx;
    logic              r_line;
    logic [BEAT_W-1:0] r_beat;
    logic              unused_low_bits;

    assign r_tag  = req_addr[ADDR_W-1:TAG_LSB];
    assign r_idx  = req_addr[TAG_LSB-1:IDX_LSB];
    assign r_line = req_addr[LINE_LSB];
    assign r_beat = req_addr[LINE_LSB-1:OFF_LSB];
    assign unused_low_bits = ^req_addr[OFF_LSB-1:0];

    logic     tag_match;
    logic     lk_hit;
    line_st_e sib_st;
    logic     cur_line;
    logic     in_pf;

    assign tag_match = (ts_rd_tag == r_tag);
    assign lk_hit    = tag_match && (ts_rd_st[r_line] != LS_I);
    assign sib_st    = ts_rd_st[~r_line];
    assign in_pf     = (seq_q.fsm == SQ_PREQ) || (seq_q.fsm == SQ_PDAT);
    assign cur_line  = in_pf ? ~seq_q.line : seq_q.line;

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        ts_tag_we   = 1'b0;
        ts_st_we    = 2'b00;
        ts_st_wd[0] = LS_I;
        ts_st_wd[1] = LS_I;
        ds_we       = 1'b0;

        unique case (seq_q.fsm)
            SQ_IDLE: begin
                if (req_valid) begin
                    seq_d.tag  = r_tag;
                    seq_d.idx  = r_idx;
                    seq_d.line = r_line;
                    seq_d.beat = r_beat;
                    seq_d.cnt  = '0;
                    if (lk_hit) begin
                        seq_d.done = 1'b1;
                        seq_d.hit  = 1'b1;
                        seq_d.data = ds_rdata;
                    end else begin
                        seq_d.fsm = SQ_DREQ;
                        if (!tag_match) begin
                            // sector changes owner: both lines drop to Invalid
                            ts_tag_we = 1'b1;
                            ts_st_we  = 2'b11;
                            seq_d.pf  = pf_en;
                        end else begin
                            seq_d.pf  = pf_en && (sib_st == LS_I);
                        end
                    end
                end
            end
            SQ_DREQ: seq_d.fsm = SQ_DDAT;
            SQ_DDAT: begin
                if (mem_rvalid) begin
                    ds_we     = 1'b1;
                    seq_d.cnt = seq_q.cnt + 1'b1;
                    if (seq_q.cnt == seq_q.beat) seq_d.data = mem_rdata;
                    if (seq_q.cnt == LAST_BEAT) begin
                        ts_st_we[seq_q.line] = 1'b1;
                        ts_st_wd[seq_q.line] = LS_E;
                        seq_d.done = 1'b1;
                        seq_d.hit  = 1'b0;
                        seq_d.fsm  = seq_q.pf ? SQ_PREQ : SQ_IDLE;
                    end
                end
            end
            SQ_PREQ: seq_d.fsm = SQ_PDAT;
            SQ_PDAT: begin
                if (mem_rvalid) begin
                    ds_we     = 1'b1;
                    seq_d.cnt = seq_q.cnt + 1'b1;
                    if (seq_q.cnt == LAST_BEAT) begin
                        ts_st_we[cur_line] = 1'b1;
                        ts_st_wd[cur_line] = LS_E;
                        seq_d.fsm = SQ_IDLE;
                    end
                end
            end
            default: seq_d.fsm = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ts_rd_idx = r_idx;
    assign ts_wr_idx = (seq_q.fsm == SQ_IDLE) ? r_idx : seq_q.idx;
    assign ts_wr_tag = r_tag;
    assign ds_raddr  = {r_idx, r_line, r_beat};
    assign ds_waddr  = {seq_q.idx, cur_line, seq_q.cnt};
    assign ds_wdata  = mem_rdata;

    assign busy      = (seq_q.fsm != SQ_IDLE);
    assign mem_req   = (seq_q.fsm == SQ_DREQ) || (seq_q.fsm == SQ_PREQ);
    assign mem_addr  = {seq_q.tag, seq_q.idx, cur_line, {LINE_LSB{1'b0}}};
    assign resp_done = seq_q.done;
    assign resp_hit  = seq_q.hit;
    assign resp_data = seq_q.data;

endmodule

// File: rtl/sector_fill_ctrl.sv
module sector_fill_ctrl
    import sfc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 32,
    parameter int SECTORS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              pf_en,
    output logic              busy,
    output logic              resp_done,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int LINE_LSB   = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(SECTORS);
    localparam int TAG_W      = ADDR_W - LINE_LSB - 1 - IDX_W;
    localparam int DS_DEPTH   = SECTORS * 2 * BEATS;
    localparam int DS_AW      = IDX_W + 1 + BEAT_W;

    logic [IDX_W-1:0]  ts_rd_idx;
    logic [TAG_W-1:0]  ts_rd_tag;
    line_st_e          ts_rd_st [2];
    logic              ts_tag_we;
    logic [IDX_W-1:0]  ts_wr_idx;
    logic [TAG_W-1:0]  ts_wr_tag;
    logic [1:0]        ts_st_we;
    line_st_e          ts_st_wd [2];
    logic [DS_AW-1:0]  ds_raddr;
    logic [DATA_W-1:0] ds_rdata;
    logic              ds_we;
    logic [DS_AW-1:0]  ds_waddr;
    logic [DATA_W-1:0] ds_wdata;

    sfc_tag_store #(
        .SECTORS (SECTORS),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ts_rd_idx),
        .rd_tag (ts_rd_tag),
        .rd_st  (ts_rd_st),
        .tag_we (ts_tag_we),
        .wr_idx (ts_wr_idx),
        .wr_tag (ts_wr_tag),
        .st_we  (ts_st_we),
        .st_wd  (ts_st_wd)
    );

    sfc_data_store #(
        .DEPTH  (DS_DEPTH),
        .DATA_W (DATA_W)
    ) u_data (
        .clk   (clk),
        .we    (ds_we),
        .waddr (ds_waddr),
        .wdata (ds_wdata),
        .raddr (ds_raddr),
        .rdata (ds_rdata)
    );

    sfc_fill_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_BYTES (LINE_BYTES),
        .SECTORS    (SECTORS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .pf_en      (pf_en),
        .busy       (busy),
        .resp_done  (resp_done),
        .resp_hit   (resp_hit),
        .resp_data  (resp_data),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .ts_rd_idx  (ts_rd_idx),
        .ts_rd_tag  (ts_rd_tag),
        .ts_rd_st   (ts_rd_st),
        .ts_tag_we  (ts_tag_we),
        .ts_wr_idx  (ts_wr_idx),
        .ts_wr_tag  (ts_wr_tag),
        .ts_st_we   (ts_st_we),
        .ts_st_wd   (ts_st_wd),
        .ds_raddr   (ds_raddr),
        .ds_rdata   (ds_rdata),
        .ds_we      (ds_we),
        .ds_waddr   (ds_waddr),
        .ds_wdata   (ds_wdata)
    );

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              resp_done,
    input logic              resp_hit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid
);

    // R5: each burst is started by a single-cycle request
    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10: bursts only while the sequencer reports busy
    a_r10_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R2: a hit is answered without leaving idle
    a_r2_hit_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done && resp_hit |-> !busy);

    // R6: a miss response follows a burst beat directly
    a_r6_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done && !resp_hit |-> $past(mem_rvalid));

    // R7: a burst started mid-activity targets the sibling line of the same sector
    a_r7_sibling_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(busy) |->
            (mem_addr[LINE_LSB] != $past(mem_addr[LINE_LSB])) &&
            (mem_addr[ADDR_W-1:LINE_LSB+1] == $past(mem_addr[ADDR_W-1:LINE_LSB+1])));

    // R10: burst address held while beats are collected
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !mem_req |-> $stable(mem_addr));

endmodule

bind sector_fill_ctrl sfc_checker #(
    .ADDR_W   (ADDR_W),
    .LINE_LSB (LINE_LSB)
) u_sfc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .resp_done  (resp_done),
    .resp_hit   (resp_hit),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid)
);

// File: tb/tb_sector_fill_ctrl.sv
`timescale 1ns/1ps
module tb_sector_fill_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        pf_en = 1'b0;
    logic        busy, resp_done, resp_hit, mem_req;
    logic [63:0] resp_data;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sector_fill_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .pf_en(pf_en), .busy(busy), .resp_done(resp_done), .resp_hit(resp_hit),
        .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit gap_mode = 1'b0;

    typedef struct { bit hit; logic [63:0] data; string req; } exp_t;
    typedef struct { logic [31:0] a; bit b2b; } burst_t;
    exp_t   expq [$];
    burst_t mlog [$];

    function automatic logic [63:0] mw(input logic [31:0] a);
        return {a, a ^ 32'hC3C3_5A5A};
    endfunction

    function automatic logic [31:0] mk(input int tg, input int idx, input int ln, input int bt);
        return (32'(tg) << 9) | (32'(idx) << 6) | (32'(ln) << 5) | (32'(bt) << 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: one burst per request, beats in ascending order
    always begin
        bit first;
        @(negedge clk);
        first = 1'b1;
        while (rst_n && mem_req) begin
            automatic logic [31:0] base = mem_addr;
            mlog.push_back('{base, !first});
            first = 1'b0;
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                if (gap_mode && k == 2) begin
                    mem_rvalid = 1'b0;
                    @(negedge clk);
                end
                mem_rvalid = 1'b1;
                mem_rdata  = mw(base + 32'(8 * k));
                @(negedge clk);
            end
            mem_rvalid = 1'b0;
        end
    end

    // response monitor
    always @(negedge clk) begin
        if (rst_n && resp_done) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R10", "unexpected response", 64'(resp_hit), 64'd0);
            end else begin
                automatic exp_t e = expq.pop_front();
                chk(resp_hit == e.hit, e.req, "resp_hit", 64'(resp_hit), 64'(e.hit));
                chk(resp_data == e.data, e.req, "resp_data", resp_data, e.data);
            end
        end
    end

    task automatic lookup(input logic [31:0] a, input bit pf, input bit exp_hit,
                          input int exp_n, input string req,
                          input bit poke = 1'b0, input logic [31:0] poke_a = '0);
        @(negedge clk);
        while (busy) @(negedge clk);
        expq.push_back('{exp_hit, mw({a[31:3], 3'b000}), req});
        req_valid = 1'b1;
        req_addr  = a;
        pf_en     = pf;
        @(negedge clk);
        req_valid = 1'b0;
        pf_en     = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            chk(busy == 1'b1, "R10", "busy during fill", 64'(busy), 64'd1);
            req_valid = 1'b1;
            req_addr  = poke_a;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, req, "responses outstanding", 64'(expq.size()), 64'd0);
        chk(mlog.size() == exp_n, req, "burst count", 64'(mlog.size()), 64'(exp_n));
        if (mlog.size() >= 1 && exp_n >= 1)
            chk(mlog[0].a == {a[31:5], 5'b0}, req, "demand burst address",
                64'(mlog[0].a), 64'({a[31:5], 5'b0}));
        if (mlog.size() >= 2 && exp_n >= 2) begin
            chk(mlog[1].a == {a[31:6], ~a[5], 5'b0}, "R7", "prefetch burst address",
                64'(mlog[1].a), 64'({a[31:6], ~a[5], 5'b0}));
            chk(mlog[1].b2b, "R7", "prefetch request right after last beat",
                64'(mlog[1].b2b), 64'd1);
        end
        mlog.delete();
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'd0);
        chk(resp_done == 1'b0, "R1", "resp_done in reset", 64'(resp_done), 64'd0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);

        // R1 R3 R6: first lookup is a tag-miss fill
        lookup(mk(5, 1, 0, 2), 1'b0, 1'b0, 1, "R3");
        // R2 R9: filled line hits
        lookup(mk(5, 1, 0, 1), 1'b0, 1'b1, 0, "R2");
        // R4: tag-hit fill of the sibling, R8 no prefetch
        lookup(mk(5, 1, 1, 3), 1'b0, 1'b0, 1, "R4");
        lookup(mk(5, 1, 0, 0), 1'b0, 1'b1, 0, "R4");
        lookup(mk(5, 1, 1, 0), 1'b0, 1'b1, 0, "R9");
        // R3: new tag invalidates the sibling line
        lookup(mk(9, 1, 1, 2), 1'b0, 1'b0, 1, "R3");
        lookup(mk(9, 1, 0, 0), 1'b0, 1'b0, 1, "R3");
        // R7: tag-miss with prefetch
        lookup(mk(3, 2, 1, 1), 1'b1, 1'b0, 2, "R7");
        lookup(mk(3, 2, 0, 3), 1'b0, 1'b1, 0, "R9");
        // R8: tag-hit fill with valid sibling skips prefetch
        lookup(mk(7, 3, 0, 0), 1'b0, 1'b0, 1, "R6");
        lookup(mk(7, 3, 1, 2), 1'b1, 1'b0, 1, "R8");
        lookup(mk(7, 3, 0, 1), 1'b1, 1'b1, 0, "R8");
        // R5: idle cycles inside bursts
        gap_mode = 1'b1;
        lookup(mk(4, 4, 0, 3), 1'b1, 1'b0, 2, "R5");
        lookup(mk(4, 4, 1, 2), 1'b0, 1'b1, 0, "R5");
        gap_mode = 1'b0;
        // R10: lookup offered while busy is ignored
        lookup(mk(6, 5, 0, 1), 1'b0, 1'b0, 1, "R10", 1'b1, mk(4, 4, 0, 3));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule